// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns bytes written by a host into asynchronous serial frames on a single output line. It has two storage stages. The first is a holding stage that the host writes. The second is a frame shifter that drives the line. While one byte is on the wire, the next one can wait in the holding stage. When the current frame ends, the waiting byte moves into the shifter on the next bit tick, so consecutive frames go out with no idle gap between them.

The frame shape is set by plain configuration inputs. These give the data length (5 to 8 bits), whether a parity bit is present, whether that parity is odd or even, and whether there are one or two stop bits. The transmitter keeps its own parity setting, so it may match or differ from whatever a companion receiver uses. The configuration is taken when a byte moves into the shifter. The host write is a plain strobe with no back-pressure: a write is taken in every cycle it is asserted. A byte still waiting in the holding stage is simply replaced by the new one. Two status outputs report whether the holding stage is empty and whether the whole transmitter has gone idle. The bit-rate tick comes from outside the block.

Top module: `ser_tx_dbuf`

## Requirements
- R1: After reset the line is high, the holding-empty flag is 1 and the transmit-complete flag is 1.
- R2: A frame begins with one low start bit, followed by the data bits, least significant bit (bus bit 0) first. The count of data bits is 5 plus the 2-bit length setting (0 gives 5 bits, 3 gives 8 bits).
- R3: With parity enabled, one parity bit follows the last data bit. When the odd-select input is 0, parity is even: the bit equals the XOR of the sent data bits. When the odd-select input is 1, parity is odd: the bit is the inverse of that XOR. With parity disabled, no parity bit is sent.
- R4: The frame ends with one high stop bit, or two when the two-stop input is 1. The line is high whenever no frame is being sent.
- R5: The holding-empty flag goes low in the cycle after a write. The byte moves into the shifter on the first bit tick at which the shifter is idle or is finishing its last stop bit. The holding-empty flag rises in that same cycle, so back-to-back frames follow each other with no gap.
- R6: A write while the holding-empty flag is low replaces the waiting byte. The frame being shifted is not disturbed.
- R7: The transmit-complete flag is 1 only while both stages are empty. It clears in the cycle after a write. It sets again when a final stop bit ends with the holding stage empty.
- R8: Every frame bit lasts exactly one bit-tick interval. The line changes only in the cycle after a tick.
- R9: The configuration inputs are applied when a byte moves into the shifter. Changing them while a frame is being sent does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one byte per asserted cycle |
| wr_data | input | 8 | Byte to send, bit 0 goes out first |
| bit_tick | input | 1 | One-cycle pulse per serial bit period |
| cfg_len | input | 2 | Data length minus 5 |
| cfg_par_en | input | 1 | 1 adds a parity bit |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_stop2 | input | 1 | 1 selects two stop bits |
| txd | output | 1 | Serial line, idles high |
| tbre | output | 1 | Holding stage empty |
| tc | output | 1 | Both stages empty (transmit complete) |

## Verification
The hardest situation to reach from the ports is a frame hand-off under load. A byte must wait in the holding stage while the shifter is mid-frame, get overwritten, and then move into the shifter on the exact tick that ends the final stop bit, all while the configuration has already changed. The bench reaches this with two concurrent branches. One branch watches the line for the start bit. At that moment the other branch changes the configuration and writes two bytes in a row. The bench then checks three things: the first frame still has its old shape, only the second written byte appears, and its start bit begins exactly one full frame length after the first start bit.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

  // frame shape selected by the host
  typedef struct packed {
    logic [1:0] len;      // data bits = minimum + len
    logic       par_en;
    logic       par_odd;
    logic       stop2;
  } tx_cfg_t;

endpackage

// File: rtl/ser_tx_frame.sv
module ser_tx_frame
  import ser_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int FW     = DATA_W + 4,
  parameter int CW     = $clog2(FW + 1)
) (
  input  logic [DATA_W-1:0] data,
  input  tx_cfg_t           cfg,
  output logic [FW-1:0]     frame,
  output logic [CW-1:0]     nbits
);

  localparam int MIN_LEN = DATA_W - 3;

  logic [CW-1:0] dlen;
  logic          par;

  always_comb begin
    dlen  = CW'(MIN_LEN) + CW'(cfg.len);
    frame = '1;            // stop bits and unused tail stay high
    frame[0] = 1'b0;       // start bit
    par   = cfg.par_odd;
    for (int i = 0; i < DATA_W; i++) begin
      if (CW'(i) < dlen) begin
        frame[i+1] = data[i];
        par        = par ^ data[i];
      end
    end
    for (int j = 1; j < FW; j++) begin
      if (cfg.par_en && (CW'(j) == dlen + CW'(1))) frame[j] = par;
    end
    nbits = CW'(2) + dlen + CW'(cfg.par_en) + CW'(cfg.stop2);
  end

endmodule

// File: rtl/ser_tx_hold.sv
module ser_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full   <= 1'b0;
      data_q <= '0;
    end else begin
      if (wr_en) begin
        full   <= 1'b1;
        data_q <= wr_data;
      end else if (take) begin
        full   <= 1'b0;
      end
    end
  end

  // a write always leaves the stage occupied (R5, R6)
  p_write_fills_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> full);

  // a transfer with no concurrent write empties the stage (R5)
  p_take_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !wr_en) |=> !full);

  // the shifter only takes when something is waiting (R5)
  p_take_needs_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> full);

endmodule

// File: rtl/ser_tx_shift.sv
module ser_tx_shift #(
  parameter int FW = 12,
  parameter int CW = $clog2(FW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_tick,
  input  logic          have_data,
  input  logic [FW-1:0] frame_in,
  input  logic [CW-1:0] nbits_in,
  output logic          take,
  output logic          done,
  output logic          busy,
  output logic          txd
);

  logic [FW-1:0] sh;
  logic [CW-1:0] remain;
  logic          last_bit;

  assign last_bit = busy && (remain == CW'(1));
  assign done     = bit_tick && last_bit;
  assign take     = bit_tick && have_data && (!busy || last_bit);
  assign txd      = busy ? sh[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '1;
      remain <= '0;
      busy   <= 1'b0;
    end else if (take) begin
      sh     <= frame_in;
      remain <= nbits_in;
      busy   <= 1'b1;
    end else if (bit_tick && busy) begin
      sh     <= {1'b1, sh[FW-1:1]};
      remain <= remain - CW'(1);
      if (last_bit) busy <= 1'b0;
    end
  end

  // the line moves only on the edge that follows a tick (R8)
  p_line_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(txd));

  // a newly loaded frame opens with a low start bit (R2)
  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (busy && !txd));

  // the final bit of any frame is a high stop bit (R4)
  p_last_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    last_bit |-> txd);

endmodule

// File: rtl/ser_tx_dbuf.sv
module ser_tx_dbuf
  import ser_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              bit_tick,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_stop2,
  output logic              txd,
  output logic              tbre,
  output logic              tc
);

  localparam int FW = DATA_W + 4;
  localparam int CW = $clog2(FW + 1);

  tx_cfg_t           cfg;
  logic              full;
  logic [DATA_W-1:0] hold_q;
  logic [FW-1:0]     frame;
  logic [CW-1:0]     nbits;
  logic              take;
  logic              done;
  logic              busy;

  assign cfg = '{len: cfg_len, par_en: cfg_par_en,
                 par_odd: cfg_par_odd, stop2: cfg_stop2};

  ser_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .take(take), .full(full), .data_q(hold_q)
  );

  ser_tx_frame #(.DATA_W(DATA_W), .FW(FW), .CW(CW)) u_frame (
    .data(hold_q), .cfg(cfg), .frame(frame), .nbits(nbits)
  );

  ser_tx_shift #(.FW(FW), .CW(CW)) u_shift (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .have_data(full),
    .frame_in(frame), .nbits_in(nbits), .take(take), .done(done),
    .busy(busy), .txd(txd)
  );

  assign tbre = !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                tc <= 1'b1;
    else if (wr_en)            tc <= 1'b0;
    else if (done && !take)    tc <= 1'b1;
  end

  // complete means both stages are empty (R7)
  p_tc_both_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> (tbre && !busy));

  // any write drops the complete flag (R7)
  p_write_clears_tc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !tc);

  // with nothing waiting, ending a frame raises complete (R7)
  p_end_sets_tc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !full && !wr_en) |=> tc);

endmodule

// File: tb/sim_ser_tx_dbuf.sv
module sim_ser_tx_dbuf;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       bit_tick = 1'b0;
  logic [1:0] cfg_len = 2'd3;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic       cfg_stop2 = 1'b0;
  logic       txd, tbre, tc;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  int tcnt = 0;
  bit ended = 1'b0;

  localparam int TICK_P = 4;

  // {len, par_en, par_odd, stop2, data, expected frame length}
  localparam logic [16:0] VEC [7] = '{
    {2'd3, 1'b0, 1'b0, 1'b0, 8'hA5, 4'd10},
    {2'd3, 1'b1, 1'b0, 1'b0, 8'h5B, 4'd11},
    {2'd3, 1'b1, 1'b1, 1'b1, 8'h5B, 4'd12},
    {2'd0, 1'b0, 1'b0, 1'b1, 8'h1F, 4'd8},
    {2'd1, 1'b1, 1'b0, 1'b0, 8'hC3, 4'd9},
    {2'd2, 1'b1, 1'b1, 1'b0, 8'h80, 4'd10},
    {2'd0, 1'b1, 1'b1, 1'b1, 8'h00, 4'd9}
  };

  ser_tx_dbuf u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .bit_tick(bit_tick), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .cfg_stop2(cfg_stop2),
    .txd(txd), .tbre(tbre), .tc(tc)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst_n) begin
      tcnt     = 0;
      bit_tick = 1'b0;
    end else begin
      bit_tick = (tcnt == TICK_P - 1);
      tcnt     = (tcnt == TICK_P - 1) ? 0 : tcnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] exp_frame(input logic [1:0] len, input logic pen,
                                            input logic odd, input logic [7:0] d);
    logic [11:0] f;
    int          l;
    logic        p;
    f = '1;
    f[0] = 1'b0;
    l = 5 + int'(len);
    p = odd;
    for (int i = 0; i < l; i++) begin
      f[1+i] = d[i];
      p = p ^ d[i];
    end
    if (pen) f[1+l] = p;
    return f;
  endfunction

  task automatic write(input logic [7:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic set_cfg(input logic [1:0] l, input logic pe, input logic po, input logic s2);
    cfg_len = l; cfg_par_en = pe; cfg_par_odd = po; cfg_stop2 = s2;
  endtask

  // waits for a start bit, samples the first cycle of each bit
  task automatic rx_frame(input logic [11:0] exp, input int n, input string req,
                          output int start);
    logic [11:0] got;
    got = '1;
    do @(negedge clk); while (txd !== 1'b0);
    start = cyc;
    chk(tbre === 1'b1, "R5 holding empty at start", int'(tbre), 1);
    for (int i = 0; i < n; i++) begin
      if (i > 0) repeat (TICK_P) @(negedge clk);
      got[i] = txd;
    end
    chk(got === exp, req, int'(got), int'(exp));
  endtask

  task automatic idle_check(input string req);
    repeat (TICK_P) @(negedge clk);
    chk(txd === 1'b1 && tc === 1'b1 && tbre === 1'b1, req,
        int'({txd, tc, tbre}), 7);
  endtask

  initial begin
    int s1, s2;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(txd === 1'b1, "R1 line high in reset", int'(txd), 1);
    chk(tbre === 1'b1, "R1 holding empty in reset", int'(tbre), 1);
    chk(tc === 1'b1, "R1 complete set in reset", int'(tc), 1);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(txd === 1'b1 && tc === 1'b1, "R4 R1 idle after reset", int'({txd, tc}), 3);

    // table walk: R2 R3 R4 R8 and flag behaviour
    for (int v = 0; v < 7; v++) begin
      logic [16:0] e;
      e = VEC[v];
      set_cfg(e[16:15], e[14], e[13], e[12]);
      write(e[11:4]);
      chk(tbre === 1'b0, "R5 holding full after write", int'(tbre), 0);
      chk(tc === 1'b0, "R7 complete cleared by write", int'(tc), 0);
      rx_frame(exp_frame(e[16:15], e[14], e[13], e[11:4]), int'(e[3:0]),
               "R2 R3 R4 R8 frame bits", s1);
      idle_check("R7 R4 idle and complete after frame");
    end

    // R6 R9 R5: overwrite during a frame, config change, no gap
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0);
    fork
      begin
        rx_frame(exp_frame(2'd3, 1'b0, 1'b0, 8'h3C), 10, "R9 R6 first frame intact", s1);
        rx_frame(exp_frame(2'd0, 1'b1, 1'b0, 8'h0E), 8, "R6 overwrite byte sent", s2);
        chk(s2 - s1 == 10 * TICK_P, "R5 back-to-back no gap", s2 - s1, 10 * TICK_P);
      end
      begin
        write(8'h3C);
        do @(negedge clk); while (txd !== 1'b0);
        set_cfg(2'd0, 1'b1, 1'b0, 1'b0);
        write(8'h11);
        write(8'h0E);
        chk(tbre === 1'b0 && tc === 1'b0, "R6 R7 waiting byte and not complete",
            int'({tbre, tc}), 0);
      end
    join
    idle_check("R7 complete after second frame");

    // R7 complete stays low between writes and load while idle
    set_cfg(2'd3, 1'b1, 1'b1, 1'b1);
    write(8'hFF);
    chk(tc === 1'b0, "R7 complete low while byte waits", int'(tc), 0);
    rx_frame(exp_frame(2'd3, 1'b1, 1'b1, 8'hFF), 12, "R3 odd parity all ones", s1);
    idle_check("R7 complete after final frame");

    if (!ended) begin
      ended = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule